// File: doc/BRIEF.md
# Key-Protected Watchdog and Interval Timer

This block is an 8-bit timer that counts prescaled ticks derived from the system clock. A 3-bit rate code picks one of eight divide ratios. When the count wraps from 0xFF to 0x00, a sticky overflow flag is raised. Depending on the mode, the wrap also produces one of two kinds of request. In watchdog mode it is a reset request or a non-maskable interrupt request. In interval mode it is an ordinary interrupt request. Software must keep rewriting the count before it wraps, or the request fires.

Both registers accept writes only when a 16-bit bus word carries the correct key in its high byte. This guards against stray stores. Reads are plain byte reads selected by `rd_sel`. The overflow flag is handled by a small state machine with three states:
- `FLG_CLEAR`: no overflow is pending.
- `FLG_SET`: an overflow has occurred and software has not yet seen it.
- `FLG_ARMED`: software has read the control byte while the flag was 1.

The transitions are:
- Any state goes to `FLG_SET` on a wrap. A wrap always wins.
- `FLG_SET` goes to `FLG_ARMED` on a control read.
- `FLG_ARMED` goes to `FLG_CLEAR` on a keyed control write whose bit 7 is 0.
- Every other combination holds the current state.

Top module: `wdog_itimer`

## Requirements
- R1: After reset the count byte, the control byte and all request outputs are 0.
- R2: A write whose high byte is 0x5A loads the low byte into the count while the timer runs. A write with any other key does not change the count.
- R3: A write whose high byte is 0xA5 loads control bits 6:0 from the low byte. Any other key leaves the control byte unchanged. The control layout is: bit 7 flag, bit 6 mode (1 = watchdog, 0 = interval), bit 5 run, bit 4 reset-type, bit 3 target select, bits 2:0 rate code.
- R4: The count advances only on prescaler ticks while run is 1. While run is 0, the count and the prescaler are held at 0.
- R5: Rate code n produces one tick every 2^(n+1) clocks. Counting from the clock edge that stores run = 1, the count reads k after exactly k*2^(n+1) further edges.
- R6: A wrap from 0xFF to 0x00 sets control bit 7. Writing 1 to bit 7 never sets the flag.
- R7: A keyed write of 0 to bit 7 clears the flag only after a control read has returned the flag as 1. Without that read, the flag stays set.
- R8: If a wrap and a clearing write land on the same edge, the flag ends up set.
- R9: In interval mode, a wrap gives a one-cycle `int_req` pulse on the clock after the wrap.
- R10: In watchdog mode, a wrap gives a one-cycle pulse on `rst_req` when bit 3 is 1, or on `nmi_req` when bit 3 is 0. At most one request is active at a time.
- R11: `rst_type` always equals control bit 4.
- R12: A keyed count write on the same edge as a tick at 0xFF wins. The count takes the written value, and no wrap, flag or request results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 16 | Key in bits 15:8, data in bits 7:0 |
| rd_en | input | 1 | Read strobe; a control read arms the flag clear |
| rd_sel | input | 1 | 0 selects the count byte, 1 the control byte |
| rd_data | output | 8 | Selected register byte |
| int_req | output | 1 | Interval interrupt pulse |
| rst_req | output | 1 | Watchdog reset request pulse |
| nmi_req | output | 1 | Watchdog non-maskable interrupt pulse |
| rst_type | output | 1 | Copy of the reset-type control bit |

## Verification
Several properties are checked on every cycle:
- A count with no tick and no write holds its value, and a wrap always leaves zero behind.
- Ticks never come back to back at slow rates.
- A wrap always leaves the flag set, and the flag cannot drop straight from `FLG_SET`.
- Bad-key writes never disturb the control byte, and the request outputs are never active together.

Other behaviour can only be shown by the bench scenarios, which compare the design against a cycle-level model every cycle. This covers the exact tick spacing for all eight rate codes, the read-then-clear order, the collision of a wrap with a clear, and the collision of a wrap with a count load. It also covers which request line each mode and target setting drives.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] KEY_COUNT = 8'h5A;
    localparam logic [BYTE_W-1:0] KEY_CTRL  = 8'hA5;

    // control byte bit positions (software-visible layout)
    localparam int POS_FLAG  = 7;
    localparam int POS_MODE  = 6;
    localparam int POS_RUN   = 5;
    localparam int POS_RTYPE = 4;
    localparam int POS_TSEL  = 3;

    typedef enum logic [1:0] {
        FLG_CLEAR = 2'd0,
        FLG_SET   = 2'd1,
        FLG_ARMED = 2'd2
    } flag_state_e;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PRE_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int RATES = 1 << SEL_W;

    logic [PRE_W-1:0] pre_q;
    logic [RATES-1:0] rate_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pre_q <= '0;
        else if (!run)   pre_q <= '0;
        else             pre_q <= pre_q + 1'b1;
    end

    // rate g fires when the low g+1 prescaler bits are all ones
    for (genvar g = 0; g < RATES; g++) begin : g_rate
        assign rate_hit[g] = &pre_q[g:0];
    end

    assign tick = run & rate_hit[sel];

    // R5: for any rate slower than divide-by-2, ticks are never adjacent
    assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel != '0) |=> (!tick || sel != $past(sel)));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter import wdt_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    output logic [BYTE_W-1:0] cnt_q,
    output logic              wrap
);
    assign wrap = run && tick && !load && (cnt_q == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!run)   cnt_q <= '0;
        else if (load)   cnt_q <= load_val;
        else if (tick)   cnt_q <= cnt_q + 1'b1;
    end

    // R4: with no tick and no load a running count holds
    assert_cnt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && !load) |=> $stable(cnt_q));

    // R6: a wrap always leaves zero behind
    assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == '0));

endmodule

// File: rtl/wdt_flag_fsm.sv
module wdt_flag_fsm import wdt_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic rd_evt,
    input  logic clr_evt,
    output logic flag
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (set_evt) begin
            state_d = FLG_SET;
        end else begin
            unique case (state_q)
                FLG_CLEAR: state_d = FLG_CLEAR;
                FLG_SET:   if (rd_evt)  state_d = FLG_ARMED;
                FLG_ARMED: if (clr_evt) state_d = FLG_CLEAR;
                default:   state_d = FLG_CLEAR;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            FLG_CLEAR: flag = 1'b0;
            FLG_SET:   flag = 1'b1;
            FLG_ARMED: flag = 1'b1;
            default:   flag = 1'b0;
        endcase
    end

    // R8: a wrap always leaves the flag set, even against a clearing write
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);

    // R7: the flag cannot drop without first being read
    assert_no_blind_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLG_SET) |=> flag);

endmodule

// File: rtl/wdog_itimer.sv
module wdog_itimer import wdt_pkg::*; #(
    parameter int PRE_W = 8,
    parameter int SEL_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2*BYTE_W-1:0] wr_data,
    input  logic                rd_en,
    input  logic                rd_sel,
    output logic [BYTE_W-1:0]   rd_data,
    output logic                int_req,
    output logic                rst_req,
    output logic                nmi_req,
    output logic                rst_type
);
    logic [BYTE_W-1:0] key;
    logic [BYTE_W-1:0] low;
    logic              wr_count, wr_ctrl, rd_ctrl, clr_evt;
    logic [POS_FLAG-1:0] ctrl_q;
    logic              run, tick, wrap, flag;
    logic [BYTE_W-1:0] cnt;

    assign key      = wr_data[2*BYTE_W-1:BYTE_W];
    assign low      = wr_data[BYTE_W-1:0];
    assign wr_count = wr_en && (key == KEY_COUNT);
    assign wr_ctrl  = wr_en && (key == KEY_CTRL);
    assign rd_ctrl  = rd_en && rd_sel;
    assign clr_evt  = wr_ctrl && !low[POS_FLAG];
    assign run      = ctrl_q[POS_RUN];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= low[POS_FLAG-1:0];
    end

    wdt_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .sel  (ctrl_q[SEL_W-1:0]),
        .tick (tick)
    );

    wdt_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (tick),
        .load    (wr_count),
        .load_val(low),
        .cnt_q   (cnt),
        .wrap    (wrap)
    );

    wdt_flag_fsm u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_evt(wrap),
        .rd_evt (rd_ctrl),
        .clr_evt(clr_evt),
        .flag   (flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_req <= 1'b0;
            rst_req <= 1'b0;
            nmi_req <= 1'b0;
        end else begin
            int_req <= wrap && !ctrl_q[POS_MODE];
            rst_req <= wrap &&  ctrl_q[POS_MODE] &&  ctrl_q[POS_TSEL];
            nmi_req <= wrap &&  ctrl_q[POS_MODE] && !ctrl_q[POS_TSEL];
        end
    end

    assign rd_data  = rd_sel ? {flag, ctrl_q} : cnt;
    assign rst_type = ctrl_q[POS_RTYPE];

    // R10: never more than one request line at a time
    assert_one_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({int_req, rst_req, nmi_req}));

    // R3: a write without the control key leaves the control byte alone
    assert_ctrl_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && key != KEY_CTRL) |=> $stable(ctrl_q));

endmodule

// File: tb/wdog_itimer_tb.sv
module wdog_itimer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        rd_sel = 1'b0;
    logic [7:0]  rd_data;
    logic        int_req, rst_req, nmi_req, rst_type;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int n_int = 0, n_rst = 0, n_nmi = 0;

    always #10 clk = ~clk;   // 50 MHz

    wdog_itimer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .int_req(int_req), .rst_req(rst_req), .nmi_req(nmi_req),
        .rst_type(rst_type)
    );

    // behavioural reference model
    bit m_wt, m_tme, m_rsts, m_rn, m_flag, m_armed, m_int, m_rst, m_nmi;
    int m_cks, m_cnt, m_pre;

    always @(posedge clk) begin
        int  div;
        bit  tk, wc, wk, ovf;
        if (!rst_n) begin
            m_wt = 0; m_tme = 0; m_rsts = 0; m_rn = 0; m_cks = 0;
            m_flag = 0; m_armed = 0; m_int = 0; m_rst = 0; m_nmi = 0;
            m_cnt = 0; m_pre = 0;
        end else begin
            div = 2 << m_cks;
            tk  = m_tme && (((m_pre + 1) % div) == 0);
            wc  = wr_en && (wr_data[15:8] == 8'h5A);
            wk  = wr_en && (wr_data[15:8] == 8'hA5);
            ovf = tk && (m_cnt == 255) && !wc;
            m_int = ovf && !m_wt;
            m_rst = ovf && m_wt && m_rn;
            m_nmi = ovf && m_wt && !m_rn;
            if (ovf) begin
                m_flag = 1; m_armed = 0;
            end else if (m_flag && !m_armed && rd_en && rd_sel) begin
                m_armed = 1;
            end else if (m_armed && wk && !wr_data[7]) begin
                m_flag = 0; m_armed = 0;
            end
            if (!m_tme)   m_cnt = 0;
            else if (wc)  m_cnt = wr_data[7:0];
            else if (tk)  m_cnt = (m_cnt + 1) % 256;
            m_pre = m_tme ? (m_pre + 1) % 256 : 0;
            if (wk) begin
                m_wt = wr_data[6]; m_tme = wr_data[5]; m_rsts = wr_data[4];
                m_rn = wr_data[3]; m_cks = wr_data[2:0];
            end
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        logic [7:0] exp_rd;
        if (rst_n) begin
            exp_rd = rd_sel ? {m_flag, m_wt, m_tme, m_rsts, m_rn, m_cks[2:0]}
                            : m_cnt[7:0];
            chk(rd_sel ? "R6 control byte" : "R4 count byte", rd_data, exp_rd);
            chk("R9 int_req", {7'd0, int_req}, {7'd0, m_int});
            chk("R10 rst_req", {7'd0, rst_req}, {7'd0, m_rst});
            chk("R10 nmi_req", {7'd0, nmi_req}, {7'd0, m_nmi});
            chk("R11 rst_type", {7'd0, rst_type}, {7'd0, m_rsts});
            if (int_req) n_int++;
            if (rst_req) n_rst++;
            if (nmi_req) n_nmi++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected < 150000", cyc);
            summary();
            $finish;
        end
    end

    function automatic logic [7:0] cb(bit wt, bit tme, bit rs, bit rn, int cks);
        return {1'b0, wt, tme, rs, rn, 3'(cks)};
    endfunction

    task automatic go();
        @(posedge clk); #3;
    endtask

    task automatic wr(input logic [7:0] k, input logic [7:0] d);
        go(); wr_en = 1'b1; wr_data = {k, d};
        go(); wr_en = 1'b0;
    endtask

    task automatic rd(input bit sel, output logic [7:0] v);
        go(); rd_en = 1'b1; rd_sel = sel;
        #5 v = rd_data;
        go(); rd_en = 1'b0;
    endtask

    function automatic bit wrap_due();
        return m_tme && (((m_pre + 1) % (2 << m_cks)) == 0) && (m_cnt == 255);
    endfunction

    initial begin
        logic [7:0] v;
        repeat (4) @(posedge clk);
        #3 rst_n = 1'b1;

        // R1 reset state
        rd(1'b0, v); chk("R1 count after reset", v, 8'h00);
        rd(1'b1, v); chk("R1 control after reset", v, 8'h00);
        chk("R1 requests after reset", {5'd0, int_req, rst_req, nmi_req}, 8'h00);

        // R2 key on count writes
        wr(8'hA5, cb(0, 1, 0, 0, 7));
        wr(8'h33, 8'h44);
        rd(1'b0, v); chk("R2 bad key count write", v, 8'h00);
        wr(8'h5A, 8'h44);
        rd(1'b0, v); chk("R2 keyed count write", v, 8'h44);

        // R3 key on control writes
        wr(8'h00, cb(1, 0, 1, 1, 2));
        rd(1'b1, v); chk("R3 bad key control write", v, cb(0, 1, 0, 0, 7));
        wr(8'h5A, cb(1, 0, 1, 1, 2));
        rd(1'b1, v); chk("R3 count key on control", v, cb(0, 1, 0, 0, 7));

        // R5 every rate code
        for (int n = 0; n < 8; n++) begin
            wr(8'hA5, cb(0, 0, 0, 0, n));
            wr(8'hA5, cb(0, 1, 0, 0, n));
            repeat (3 * (2 << n) - 1) go();
            rd(1'b0, v); chk($sformatf("R5 rate code %0d", n), v, 8'h03);
        end

        // R6 / R9 interval wrap, R7 blind clear
        wr(8'hA5, cb(0, 1, 0, 0, 0));
        n_int = 0;
        wr(8'h5A, 8'hFD);
        repeat (20) go();
        chk("R9 one interval pulse", 8'(n_int), 8'd1);
        wr(8'hA5, cb(0, 1, 0, 0, 0));
        rd(1'b1, v); chk("R7 clear without read ignored", v[7], 1'b1);
        chk("R6 flag set on wrap", v[7], 1'b1);
        wr(8'hA5, cb(0, 1, 0, 0, 0));
        rd(1'b1, v); chk("R7 clear after read", v[7], 1'b0);
        wr(8'hA5, 8'h80 | cb(0, 1, 0, 0, 0));
        rd(1'b1, v); chk("R6 writing 1 has no effect", v[7], 1'b0);

        // R8 wrap and clear on the same edge
        wr(8'h5A, 8'hFD);
        while (!m_flag) go();
        rd(1'b1, v);
        wr(8'h5A, 8'hF0);
        while (!wrap_due()) go();
        wr_en = 1'b1; wr_data = {8'hA5, cb(0, 1, 0, 0, 0)};
        go(); wr_en = 1'b0;
        rd(1'b1, v); chk("R8 set beats clear", v[7], 1'b1);

        // R12 count load beats a wrap
        wr(8'hA5, cb(0, 1, 0, 0, 0));
        rd(1'b1, v); chk("R7 second clear", v[7], 1'b0);
        n_int = 0;
        wr(8'h5A, 8'hF8);
        while (!wrap_due()) go();
        wr_en = 1'b1; wr_data = {8'h5A, 8'h10};
        go(); wr_en = 1'b0;
        rd(1'b0, v); chk("R12 load wins over wrap", v, 8'h10);
        rd(1'b1, v); chk("R12 no flag from suppressed wrap", v[7], 1'b0);
        chk("R12 no pulse from suppressed wrap", 8'(n_int), 8'd0);

        // R10 / R11 watchdog mode, reset target
        wr(8'hA5, cb(1, 1, 1, 1, 0));
        n_rst = 0; n_nmi = 0; n_int = 0;
        wr(8'h5A, 8'hFD);
        repeat (20) go();
        chk("R10 reset target pulse", 8'(n_rst), 8'd1);
        chk("R10 no nmi for reset target", 8'(n_nmi), 8'd0);
        chk("R11 rst_type high", {7'd0, rst_type}, 8'd1);

        // R10 / R11 watchdog mode, NMI target
        wr(8'hA5, cb(1, 1, 0, 0, 0));
        n_rst = 0; n_nmi = 0;
        wr(8'h5A, 8'hFD);
        repeat (20) go();
        chk("R10 nmi target pulse", 8'(n_nmi), 8'd1);
        chk("R10 no reset for nmi target", 8'(n_rst), 8'd0);
        chk("R9 no interval pulse in watchdog", 8'(n_int), 8'd0);
        chk("R11 rst_type low", {7'd0, rst_type}, 8'd0);

        // R4 stopping clears and holds the count
        wr(8'hA5, cb(0, 0, 0, 0, 0));
        repeat (10) go();
        rd(1'b0, v); chk("R4 count held at zero when stopped", v, 8'h00);
        wr(8'h5A, 8'h77);
        rd(1'b0, v); chk("R4 load ignored while stopped", v, 8'h00);

        summary();
        $finish;
    end
endmodule